// File: doc/BRIEF.md
# Operand Addressing-Mode Fetch Unit

This block resolves one source operand for an ALU instruction. An instruction is offered with a mode code, two register indices (base and index), a signed 32-bit constant and an element-size code. The unit reads an internal register file and, for memory modes, issues word reads through one request/valid read port. It returns the operand together with a one-cycle completion pulse. For the post-increment and pre-decrement modes it also writes an updated base register back into the same file.

The register file also has a result write port. Through this port the surrounding datapath deposits ALU results, and through it the file is loaded. Each mode follows its own memory sequence. Register, constant and unrecognised codes finish one cycle after they are accepted. Single-read modes finish once their read returns. The pointer-chasing mode issues two reads in a row. The unit accepts a new instruction only while it is idle.

Top module: `opnd_fetch_unit`

## Requirements
- R1: Mode code 0 (register) returns the base register's value, makes no memory read, and raises done on the cycle after start is accepted.
- R2: Mode code 1 (constant) returns the constant input unchanged, makes no memory read, and raises done on the cycle after acceptance.
- R3: Mode code 2 (displacement) makes one read at constant + base register and returns the word read.
- R4: Mode code 3 (register deferred) makes one read at the base register's value and returns the word read.
- R5: Mode code 4 (indexed) makes one read at base register + index register and returns the word read.
- R6: Mode code 5 (absolute) makes one read at the constant alone and returns the word read.
- R7: Mode code 6 (pointer indirect) makes exactly two reads. The first is at the base register's value. The second is at the word that the first returned. The word from the second read is the operand.
- R8: Mode code 7 (post-increment) reads at the base register's current value. It then leaves the base register increased by the element size d. The write-back happens once, in the cycle where done is high. The element size is d = 2^size_log2, so codes 0..3 give 1, 2, 4 and 8.
- R9: Mode code 8 (pre-decrement) reads at base − d and leaves the base register equal to base − d. A pre-decrement followed by a post-increment on the same register and size reads the same address twice.
- R10: Mode code 9 (scaled) makes one read at constant + base + index × d and returns the word read.
- R11: Codes 10 to 15 raise done on the cycle after acceptance, with illegal = 1, operand = 0 and no memory read. Every legal code finishes with illegal = 0.
- R12: Out of reset the unit is idle with no read request. While a read is outstanding, mem_addr stays constant until mem_valid arrives. A start that arrives while busy is ignored. Done is high for exactly one cycle per accepted instruction.
- R13: Register 0 always reads as zero. Writes to it from either the result port or a base update have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer an instruction; taken only when idle |
| mode | input | 4 | Addressing-mode code |
| base_idx | input | 4 | Base register index |
| index_idx | input | 4 | Index register index |
| imm | input | 32 | Signed displacement, constant or absolute address |
| size_log2 | input | 2 | Element size code, d = 2^size_log2 |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 32 | Resolved operand, held until the next completion |
| illegal | output | 1 | The last completed code was not a legal mode |
| mem_req | output | 1 | Read request, held until mem_valid |
| mem_addr | output | 32 | Read address |
| mem_valid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| rf_we | input | 1 | Result write enable into the register file |
| rf_widx | input | 4 | Result write register index |
| rf_wdata | input | 32 | Result write data |

## Verification
The hardest situation to reach from the ports is a second start that arrives while a read is stalled. In that situation the address must stay fixed, the new offer must be dropped, and exactly one completion must follow. The bench's memory model therefore has an adjustable response latency, and a directed test pulses start, carrying a different mode, in the middle of a long wait. The pointer-indirect chain is hard to observe, as is the pairing of pre-decrement with post-increment. For these the model logs every request address, and the bench compares the log against addresses it derives from its own copy of the registers.

// File: rtl/opf_pkg.sv
package opf_pkg;

  localparam int unsigned OPF_MODE_W   = 4;
  localparam int unsigned OPF_MODE_CNT = 10;

  typedef enum logic [OPF_MODE_W-1:0] {
    M_REG    = 4'd0,
    M_IMM    = 4'd1,
    M_DISP   = 4'd2,
    M_DEFER  = 4'd3,
    M_INDEX  = 4'd4,
    M_ABS    = 4'd5,
    M_INDIR  = 4'd6,
    M_AINC   = 4'd7,
    M_ADEC   = 4'd8,
    M_SCALED = 4'd9
  } opf_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_FIN
  } opf_state_e;

  typedef struct packed {
    logic needs_mem;
    logic two_reads;
    logic auto_upd;
    logic illegal;
  } opf_class_t;

  function automatic opf_class_t opf_classify(input logic [OPF_MODE_W-1:0] m);
    opf_class_t c;
    c.illegal   = (32'(m) >= OPF_MODE_CNT);
    c.needs_mem = !c.illegal && (m != M_REG) && (m != M_IMM);
    c.two_reads = (m == M_INDIR);
    c.auto_upd  = (m == M_AINC) || (m == M_ADEC);
    return c;
  endfunction

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);

  logic [NREGS*DATA_W-1:0] flat;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign flat[g*DATA_W +: DATA_W] = '0;
    end else begin : g_live
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (we && widx == IDX_W'(g))
          q <= wdata;
      end
      assign flat[g*DATA_W +: DATA_W] = q;
    end
  end

  assign ra_data = flat[int'(ra_idx)*DATA_W +: DATA_W];
  assign rb_data = flat[int'(rb_idx)*DATA_W +: DATA_W];

endmodule

// File: rtl/opf_addr_gen.sv
module opf_addr_gen
  import opf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SZ_W   = 2
) (
  input  logic [OPF_MODE_W-1:0] mode,
  input  logic [DATA_W-1:0]     base_val,
  input  logic [DATA_W-1:0]     index_val,
  input  logic [DATA_W-1:0]     imm,
  input  logic [SZ_W-1:0]       size_log2,
  output logic [DATA_W-1:0]     first_addr,
  output logic [DATA_W-1:0]     direct_val,
  output logic [DATA_W-1:0]     wb_val
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  // element size in address units, a power of two chosen by size_log2
  function automatic logic [DATA_W-1:0] elem_size(input logic [SZ_W-1:0] s);
    return ONE << s;
  endfunction

  // index scaled by the element size: a shift, not a multiply
  function automatic logic [DATA_W-1:0] scale_by(input logic [DATA_W-1:0] v,
                                                 input logic [SZ_W-1:0]   s);
    return v << s;
  endfunction

  function automatic logic [DATA_W-1:0] add3(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b,
                                             input logic [DATA_W-1:0] c);
    return a + b + c;
  endfunction

  logic [DATA_W-1:0] d_val;
  logic [DATA_W-1:0] base_inc;
  logic [DATA_W-1:0] base_dec;
  logic [DATA_W-1:0] scaled_idx;

  assign d_val      = elem_size(size_log2);
  assign base_inc   = base_val + d_val;
  assign base_dec   = base_val - d_val;
  assign scaled_idx = scale_by(index_val, size_log2);

  always_comb begin
    first_addr = '0;
    direct_val = '0;
    wb_val     = base_inc;
    case (mode)
      M_REG:    direct_val = base_val;
      M_IMM:    direct_val = imm;
      M_DISP:   first_addr = imm + base_val;
      M_DEFER:  first_addr = base_val;
      M_INDEX:  first_addr = base_val + index_val;
      M_ABS:    first_addr = imm;
      M_INDIR:  first_addr = base_val;
      M_AINC:   first_addr = base_val;
      M_ADEC: begin
        first_addr = base_dec;
        wb_val     = base_dec;
      end
      M_SCALED: first_addr = add3(imm, base_val, scaled_idx);
      default: begin
        first_addr = '0;
        direct_val = '0;
      end
    endcase
  end

endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  opf_class_t        cls,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [DATA_W-1:0] first_addr,
  input  logic [DATA_W-1:0] direct_val,
  input  logic [DATA_W-1:0] wb_val,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] operand,
  output logic              illegal,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  output logic              wb_we,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);

  opf_state_e        state;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] wbv_q;
  logic [IDX_W-1:0]  widx_q;
  logic              illegal_q;
  logic              two_q;
  logic              auto_q;

  // named internal events
  logic start_accept;
  logic rd_hit;
  logic indir_step;
  logic last_read;

  assign start_accept = start && (state == ST_IDLE);
  assign rd_hit       = mem_req && mem_valid;
  assign indir_step   = rd_hit && (state == ST_RD1) && two_q;
  assign last_read    = rd_hit && !indir_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      result_q  <= '0;
      wbv_q     <= '0;
      widx_q    <= '0;
      illegal_q <= 1'b0;
      two_q     <= 1'b0;
      auto_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_accept) begin
            illegal_q <= cls.illegal;
            two_q     <= cls.two_reads;
            auto_q    <= cls.auto_upd;
            wbv_q     <= wb_val;
            widx_q    <= base_idx;
            addr_q    <= first_addr;
            if (cls.needs_mem) begin
              state <= ST_RD1;
            end else begin
              result_q <= cls.illegal ? '0 : direct_val;
              state    <= ST_FIN;
            end
          end
        end
        ST_RD1, ST_RD2: begin
          if (indir_step) begin
            addr_q <= mem_rdata;
            state  <= ST_RD2;
          end else if (last_read) begin
            result_q <= mem_rdata;
            state    <= ST_FIN;
          end
        end
        ST_FIN: begin
          state  <= ST_IDLE;
          auto_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign mem_req  = (state == ST_RD1) || (state == ST_RD2);
  assign mem_addr = addr_q;
  assign operand  = result_q;
  assign illegal  = illegal_q;
  assign wb_we    = done && auto_q;
  assign wb_idx   = widx_q;
  assign wb_data  = wbv_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))) else $error("address moved while waiting"); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done longer than one cycle"); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req) else $error("request while idle"); // R12
  AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rst_n) (start_accept && cls.illegal) |=> (done && illegal && !mem_req && operand == '0)) else $error("illegal code not finished at once"); // R11
  AST_DIRECT_FAST: assert property (@(posedge clk) disable iff (!rst_n) (start_accept && !cls.needs_mem && !cls.illegal) |=> (done && !illegal)) else $error("direct mode slow"); // R1
  AST_INDIR_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) indir_step |=> (mem_req && mem_addr == $past(mem_rdata))) else $error("second read not at pointer"); // R7
  AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) wb_we |-> (done && $past(auto_q))) else $error("write-back outside done"); // R8

endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
  import opf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  parameter int SZ_W   = 2,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [OPF_MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]      base_idx,
  input  logic [IDX_W-1:0]      index_idx,
  input  logic [DATA_W-1:0]     imm,
  input  logic [SZ_W-1:0]       size_log2,
  output logic                  busy,
  output logic                  done,
  output logic [DATA_W-1:0]     operand,
  output logic                  illegal,
  output logic                  mem_req,
  output logic [DATA_W-1:0]     mem_addr,
  input  logic                  mem_valid,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic                  rf_we,
  input  logic [IDX_W-1:0]      rf_widx,
  input  logic [DATA_W-1:0]     rf_wdata
);

  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] index_val;
  logic [DATA_W-1:0] first_addr;
  logic [DATA_W-1:0] direct_val;
  logic [DATA_W-1:0] wb_val;
  logic              wb_we;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;
  opf_class_t        cls;

  // register file write arbitration: the base update wins over the result port
  logic              rf_any_we;
  logic [IDX_W-1:0]  rf_sel_idx;
  logic [DATA_W-1:0] rf_sel_data;
  logic              start_ok;

  assign cls         = opf_classify(mode);
  assign rf_any_we   = wb_we || rf_we;
  assign rf_sel_idx  = wb_we ? wb_idx  : rf_widx;
  assign rf_sel_data = wb_we ? wb_data : rf_wdata;
  assign start_ok    = start && !busy;

  opf_regfile #(
    .DATA_W (DATA_W),
    .NREGS  (NREGS)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_any_we),
    .widx    (rf_sel_idx),
    .wdata   (rf_sel_data),
    .ra_idx  (base_idx),
    .ra_data (base_val),
    .rb_idx  (index_idx),
    .rb_data (index_val)
  );

  opf_addr_gen #(
    .DATA_W (DATA_W),
    .SZ_W   (SZ_W)
  ) agen_i (
    .mode       (mode),
    .base_val   (base_val),
    .index_val  (index_val),
    .imm        (imm),
    .size_log2  (size_log2),
    .first_addr (first_addr),
    .direct_val (direct_val),
    .wb_val     (wb_val)
  );

  opf_ctrl #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cls        (cls),
    .base_idx   (base_idx),
    .first_addr (first_addr),
    .direct_val (direct_val),
    .wb_val     (wb_val),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .operand    (operand),
    .illegal    (illegal),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .wb_we      (wb_we),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data)
  );

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (start_ok && mode == M_REG && base_idx == '0) |=> (done && operand == '0)) else $error("register 0 not zero"); // R13
  AST_IMM_PASS: assert property (@(posedge clk) disable iff (!rst_n) (start_ok && mode == M_IMM) |=> (done && operand == $past(imm))) else $error("constant altered"); // R2

endmodule

// File: tb/opnd_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module opnd_fetch_unit_tb_top;

  localparam int DW = 32;
  localparam int NR = 16;
  localparam int IW = 4;

  typedef struct packed {
    logic [3:0]    m;
    logic [IW-1:0] b;
    logic [IW-1:0] x;
    logic [DW-1:0] k;
    logic [1:0]    s;
    logic [1:0]    l;
  } vec_t;

  // mode, base, index, constant, size code, response latency
  localparam vec_t VECS [0:15] = '{
    '{4'd0, 4'd3,  4'd0, 32'h0,        2'd0, 2'd0},
    '{4'd1, 4'd0,  4'd0, 32'hDEADBEEF, 2'd0, 2'd0},
    '{4'd2, 4'd4,  4'd0, 32'hFFFFFFF8, 2'd0, 2'd1},
    '{4'd3, 4'd6,  4'd0, 32'h0,        2'd0, 2'd0},
    '{4'd4, 4'd2,  4'd7, 32'h0,        2'd0, 2'd2},
    '{4'd5, 4'd0,  4'd0, 32'h00002468, 2'd0, 2'd3},
    '{4'd6, 4'd5,  4'd0, 32'h0,        2'd0, 2'd1},
    '{4'd7, 4'd9,  4'd0, 32'h0,        2'd2, 2'd0},
    '{4'd0, 4'd9,  4'd0, 32'h0,        2'd0, 2'd0},
    '{4'd8, 4'd10, 4'd0, 32'h0,        2'd3, 2'd2},
    '{4'd0, 4'd10, 4'd0, 32'h0,        2'd0, 2'd0},
    '{4'd9, 4'd3,  4'd4, 32'h00000010, 2'd2, 2'd1},
    '{4'd9, 4'd3,  4'd4, 32'hFFFFFFF0, 2'd3, 2'd0},
    '{4'd12, 4'd1, 4'd1, 32'h00000005, 2'd0, 2'd0},
    '{4'd4, 4'd0,  4'd8, 32'h0,        2'd0, 2'd0},
    '{4'd7, 4'd11, 4'd0, 32'h0,        2'd0, 2'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [IW-1:0] base_idx = '0;
  logic [IW-1:0] index_idx = '0;
  logic [DW-1:0] imm = '0;
  logic [1:0]    size_log2 = '0;
  logic          busy, done, illegal, mem_req;
  logic [DW-1:0] operand, mem_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          rf_we = 1'b0;
  logic [IW-1:0] rf_widx = '0;
  logic [DW-1:0] rf_wdata = '0;

  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  int wait_cnt = 0;
  int lat_cfg = 0;
  logic [DW-1:0] rd_log [0:1023];
  logic [DW-1:0] shadow [0:NR-1];

  always #2.5 clk = ~clk;

  opnd_fetch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .base_idx(base_idx), .index_idx(index_idx), .imm(imm), .size_log2(size_log2),
    .busy(busy), .done(done), .operand(operand), .illegal(illegal),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
  );

  function automatic logic [DW-1:0] mem_word(input logic [DW-1:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16]} + 32'h0101_0000;
  endfunction

  // memory model with adjustable response latency and an address log
  always @(posedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat_cfg) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem_word(mem_addr);
        rd_log[rd_cnt & 1023] <= mem_addr;
        rd_cnt   <= rd_cnt + 1;
        wait_cnt <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic wr_reg(input int i, input logic [DW-1:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_widx = IW'(i); rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    if (i != 0) shadow[i] = v;
  endtask

  task automatic run_op(input logic [3:0] m, input logic [IW-1:0] b, input logic [IW-1:0] x,
                        input logic [DW-1:0] k, input logic [1:0] s, input int l);
    string tg;
    logic [DW-1:0] bv, xv, dd, ea1, ea2, eop;
    int enr, r0, t;
    logic eill;
    tg = tag_of(m);
    bv = shadow[b]; xv = shadow[x];
    dd = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : (s == 2'd2) ? 32'd4 : 32'd8;
    ea1 = '0; ea2 = '0; enr = 1; eill = 1'b0;
    case (m)
      4'd0: begin enr = 0; eop = bv; end
      4'd1: begin enr = 0; eop = k; end
      4'd2: ea1 = k + bv;
      4'd3: ea1 = bv;
      4'd4: ea1 = bv + xv;
      4'd5: ea1 = k;
      4'd6: begin enr = 2; ea1 = bv; ea2 = mem_word(bv); end
      4'd7: ea1 = bv;
      4'd8: ea1 = bv - dd;
      4'd9: ea1 = k + bv + xv * dd;
      default: begin enr = 0; eop = '0; eill = 1'b1; end
    endcase
    if (enr == 1) eop = mem_word(ea1);
    if (enr == 2) eop = mem_word(ea2);
    lat_cfg = l;
    @(negedge clk);
    r0 = rd_cnt;
    mode = m; base_idx = b; index_idx = x; imm = k; size_log2 = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(tg, "done seen", 32'(done), 32'd1);
    chk(tg, "operand", operand, eop);
    chk(tg, "illegal flag", 32'(illegal), 32'(eill));
    chk(tg, "read count", 32'(rd_cnt - r0), 32'(enr));
    if (enr == 0) chk(tg, "cycles to done", 32'(t), 32'd0);
    if (enr >= 1) chk(tg, "first address", rd_log[r0 & 1023], ea1);
    if (enr == 2) chk(tg, "second address", rd_log[(r0 + 1) & 1023], ea2);
    @(negedge clk);
    chk("R12", "done one cycle", 32'(done), 32'd0);
    if (m == 4'd7 && b != 0) shadow[b] = bv + dd;
    if (m == 4'd8 && b != 0) shadow[b] = bv - dd;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int a0, ndone;
    logic [DW-1:0] held;
    for (int i = 0; i < NR; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "busy after reset", 32'(busy), 32'd0);
    chk("R12", "done after reset", 32'(done), 32'd0);
    chk("R12", "request after reset", 32'(mem_req), 32'd0);

    for (int i = 1; i < NR; i++) wr_reg(i, 32'h0000_1000 + 32'(i) * 32'h44);
    wr_reg(5, 32'hFFFF_FF00);

    for (int i = 0; i < 16; i++)
      run_op(VECS[i].m, VECS[i].b, VECS[i].x, VECS[i].k, VECS[i].s, int'(VECS[i].l));

    // R11 highest code with a slow memory configured
    run_op(4'd15, 4'd2, 4'd3, 32'h1234, 2'd1, 3);
    // R7 pointer chain from register 0 with a slow memory
    run_op(4'd6, 4'd0, 4'd0, 32'h0, 2'd0, 3);

    // R9 pre-decrement then post-increment pair on one register
    a0 = rd_cnt;
    run_op(4'd8, 4'd12, 4'd0, 32'h0, 2'd2, 1);
    run_op(4'd7, 4'd12, 4'd0, 32'h0, 2'd2, 0);
    chk("R9", "push/pop same address", rd_log[(a0 + 1) & 1023], rd_log[a0 & 1023]);
    run_op(4'd0, 4'd12, 4'd0, 32'h0, 2'd0, 0);

    // R13 register 0 ignores writes from both sources
    wr_reg(0, 32'hDEADBEEF);
    run_op(4'd0, 4'd0, 4'd0, 32'h0, 2'd0, 0);
    run_op(4'd7, 4'd0, 4'd0, 32'h0, 2'd2, 1);
    run_op(4'd0, 4'd0, 4'd0, 32'h0, 2'd0, 0);

    // R12 start while busy is dropped, address held during a long wait
    lat_cfg = 4;
    @(negedge clk);
    a0 = rd_cnt;
    mode = 4'd3; base_idx = 4'd6; imm = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    held = mem_addr;
    @(negedge clk);
    mode = 4'd1; imm = 32'h1111_1111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12", "address held", mem_addr, held);
    chk("R12", "address value", held, shadow[6]);
    ndone = 0;
    for (int c = 0; c < 14; c++) begin
      if (mem_req && mem_addr !== held) chk("R12", "address stable", mem_addr, held);
      if (done) begin
        ndone++;
        chk("R12", "operand after dropped start", operand, mem_word(shadow[6]));
      end
      @(negedge clk);
    end
    chk("R12", "one completion", 32'(ndone), 32'd1);
    chk("R12", "one read", 32'(rd_cnt - a0), 32'd1);

    finish_run();
  end

endmodule